// File: doc/BRIEF.md
# Single-Wire Bus Slave Link Layer

This block is the bit-level slave end of a single-wire, open-drain, wired-AND bus. It runs on a system clock many times faster than the bus timing. It watches a synchronized copy of the bus and pulls the bus low through one output. Every bus event starts when the master pulls the line low. The length of that low and the moment it ends decide whether the event is a bus reset or a data time slot.

A reset makes the block raise a one-cycle reset strobe and then answer with a presence pulse. In a data slot the block either samples the line to receive a bit or, when the upper layer is transmitting a zero, holds the line low for a fixed time. A falling-edge request strobe tells the upper layer to present its next transmit bit. A completion strobe, together with a received-bit strobe on receive slots, reports each finished slot.

The block has two timing sets, regular and fast (overdrive). The upper layer turns fast mode on with a one-cycle pulse. In fast mode a shorter low inside a set window is a fast reset, which keeps the mode. A low that reaches the full regular reset length always clears fast mode. All timing values are parameters counted in system-clock cycles.

Top module: `swire_slave_link`

## Requirements
- R1: After rst_n is released, bus_pull is 0, od_mode is 0, and tx_req, rx_valid, slot_done and rst_pulse are all 0.
- R2: A bus low lasting at least RST_CYC clocks is a reset. It produces exactly one single-cycle rst_pulse, and the aborted slot it began as produces no slot_done and no rx_valid.
- R3: After a regular reset, bus_pull first asserts PRES_WAIT+3 clocks after bus_in rises (two clocks of synchronizing, one of edge detection, then the wait), and it stays asserted for exactly PRES_LEN clocks.
- R4: With od_mode at 1, a bus low of OD_RST_MIN to OD_RST_MAX clocks inclusive is a fast reset. It produces one rst_pulse, leaves od_mode at 1, and is answered by a presence pull that starts OD_PRES_WAIT+3 clocks after the rise and lasts OD_PRES_LEN clocks.
- R5: A reset of at least RST_CYC clocks clears od_mode to 0, even in the middle of a transmitting slot. Its presence pull then uses the regular timing.
- R6: A low that is not a reset is an ordinary data slot and produces no rst_pulse. In regular mode this covers a low of fast-reset length. In fast mode it covers a low shorter than OD_RST_MIN and a low longer than OD_RST_MAX but shorter than RST_CYC.
- R7: With tx_active at 0, each slot ends with a one-cycle slot_done together with rx_valid. rx_bit is the line level sampled SAMP clocks (OD_SAMP in fast mode) after the falling edge is detected, so it is 1 for a short master low and 0 for a low held past the sample point.
- R8: Each master falling edge that starts a slot gives exactly one single-cycle tx_req.
- R9: With tx_active at 1 and tx_bit at 0, bus_pull is asserted for exactly HOLD clocks (OD_HOLD in fast mode). With tx_bit at 1, bus_pull stays 0. A transmitting slot gives slot_done but no rx_valid.
- R10: A one-cycle od_set sets od_mode to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw bus level (1 = released) |
| bus_pull | output | 1 | 1 = pull the bus low |
| od_set | input | 1 | One-cycle request to enter fast mode |
| od_mode | output | 1 | 1 = fast timing set active |
| tx_active | input | 1 | Upper layer is transmitting in the next slot |
| tx_bit | input | 1 | Bit to transmit, read on the cycle tx_req is high |
| tx_req | output | 1 | Slot-start strobe |
| rx_bit | output | 1 | Sampled bit, valid with rx_valid |
| rx_valid | output | 1 | Received-bit strobe |
| slot_done | output | 1 | Slot completion strobe |
| rst_pulse | output | 1 | Bus reset strobe |

## Verification
The hardest case to reach is a reset that lands in the middle of a slot in which the block itself is driving a zero while fast mode is on. Here the mode clear, the abort of the slot and the choice of presence timing all interact. The bench reaches it by first entering fast mode and running fast slots and a fast reset. It then sets tx_active with a zero bit and holds the master low past the regular reset length. Finally it measures the presence gap and width at the ports, and checks od_mode and the strobe counts.

// File: rtl/swl_pkg.sv
package swl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RWAIT,
    ST_PWAIT,
    ST_PDRIVE
  } swl_state_e;

  // Pick the timing value of the active speed.
  function automatic int unsigned pick_t(input logic fast,
                                         input int unsigned slow_v,
                                         input int unsigned fast_v);
    return fast ? fast_v : slow_v;
  endfunction

  // Inclusive range test used for the fast-reset window.
  function automatic logic in_span(input int unsigned v,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic int unsigned max2(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swl_sync.sv
module swl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic line,
  output logic fall,
  output logic rise
);
  logic s1, s2, line_d;

  // Released bus is high, so all stages reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      line_d <= 1'b1;
    end else begin
      s1     <= bus_in;
      s2     <= s1;
      line_d <= s2;
    end
  end

  assign line = s2;
  assign fall = line_d & ~s2;
  assign rise = ~line_d & s2;

endmodule

// File: rtl/swl_low_timer.sv
module swl_low_timer #(
  parameter int unsigned RST_CYC    = 4800,
  parameter int unsigned OD_RST_MIN = 480,
  parameter int unsigned OD_RST_MAX = 800,
  parameter int unsigned CW         = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic rise,
  input  logic freeze,
  input  logic od_mode,
  output logic long_hit,
  output logic od_hit
);
  import swl_pkg::*;

  localparam logic [CW-1:0] LIMIT = CW'(RST_CYC);
  localparam logic [CW-1:0] HITV  = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt;

  // Counts low clocks; cleared while high or while the block drives presence.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (freeze || line)  cnt <= '0;
    else if (cnt != LIMIT)    cnt <= cnt + 1'b1;
  end

  assign long_hit = !line && !freeze && (cnt == HITV);
  assign od_hit   = rise && od_mode && in_span(32'(cnt), OD_RST_MIN, OD_RST_MAX);

endmodule

// File: rtl/swl_slot_engine.sv
module swl_slot_engine #(
  parameter int unsigned PRES_WAIT    = 300,
  parameter int unsigned PRES_LEN     = 1200,
  parameter int unsigned OD_PRES_WAIT = 30,
  parameter int unsigned OD_PRES_LEN  = 120,
  parameter int unsigned SAMP         = 300,
  parameter int unsigned OD_SAMP      = 35,
  parameter int unsigned HOLD         = 150,
  parameter int unsigned OD_HOLD      = 20,
  parameter int unsigned TLIM         = 1201,
  parameter int unsigned TW           = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic fall,
  input  logic long_hit,
  input  logic od_hit,
  input  logic od_set,
  input  logic tx_active,
  input  logic tx_bit,
  output logic bus_pull,
  output logic od_mode,
  output logic tx_req,
  output logic rx_bit,
  output logic rx_valid,
  output logic slot_done,
  output logic rst_pulse,
  output logic freeze
);
  import swl_pkg::*;

  localparam logic [TW-1:0] TSAT = TW'(TLIM);

  swl_state_e    state;
  logic [TW-1:0] tcnt, pcnt;
  logic          pres_od, tx_zero, tx_act, smp, od_q;
  logic [TW-1:0] samp_v, hold_v, wait_v, len_v;
  logic          long_ok;

  assign samp_v  = TW'(pick_t(od_q, SAMP, OD_SAMP));
  assign hold_v  = TW'(pick_t(od_q, HOLD, OD_HOLD));
  assign wait_v  = TW'(pick_t(pres_od, PRES_WAIT, OD_PRES_WAIT));
  assign len_v   = TW'(pick_t(pres_od, PRES_LEN, OD_PRES_LEN));
  assign long_ok = long_hit && (state == ST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      pcnt      <= '0;
      pres_od   <= 1'b0;
      tx_zero   <= 1'b0;
      tx_act    <= 1'b0;
      smp       <= 1'b1;
      od_q      <= 1'b0;
      tx_req    <= 1'b0;
      rx_bit    <= 1'b0;
      rx_valid  <= 1'b0;
      slot_done <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      tx_req    <= 1'b0;
      rx_valid  <= 1'b0;
      slot_done <= 1'b0;
      rst_pulse <= 1'b0;
      if (long_ok)     od_q <= 1'b0;
      else if (od_set) od_q <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (fall) begin
            state  <= ST_SLOT;
            tcnt   <= '0;
            tx_req <= 1'b1;
          end
        end
        ST_SLOT: begin
          if (long_ok) begin
            state     <= ST_RWAIT;
            rst_pulse <= 1'b1;
          end else if (od_hit) begin
            state     <= ST_PWAIT;
            pcnt      <= '0;
            pres_od   <= 1'b1;
            rst_pulse <= 1'b1;
          end else begin
            if (tcnt != TSAT) tcnt <= tcnt + 1'b1;
            if (tcnt == '0) begin
              tx_act  <= tx_active;
              tx_zero <= tx_active & ~tx_bit;
            end
            if (tcnt == samp_v) smp <= line;
            if ((tcnt > samp_v) && line) begin
              state     <= ST_IDLE;
              slot_done <= 1'b1;
              rx_valid  <= ~tx_act;
              rx_bit    <= smp;
            end
          end
        end
        ST_RWAIT: begin
          if (line) begin
            state   <= ST_PWAIT;
            pcnt    <= '0;
            pres_od <= 1'b0;
          end
        end
        ST_PWAIT: begin
          if (pcnt == wait_v - 1'b1) begin
            state <= ST_PDRIVE;
            pcnt  <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_PDRIVE: begin
          if (pcnt == len_v - 1'b1) state <= ST_IDLE;
          else                      pcnt  <= pcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_pull = ((state == ST_SLOT) && tx_zero && (tcnt != '0) && (tcnt <= hold_v))
                  || (state == ST_PDRIVE);
  assign od_mode  = od_q;
  assign freeze   = (state == ST_PWAIT) || (state == ST_PDRIVE);

  AST_LONG_RST_CLEARS_OD: assert property (@(posedge clk) disable iff (!rst_n)
    (long_hit && state == ST_SLOT) |=> (rst_pulse && !od_mode)); // R5
  AST_OD_RST_KEEPS_OD: assert property (@(posedge clk) disable iff (!rst_n)
    (od_hit && od_mode && state == ST_SLOT) |=> (rst_pulse && od_mode)); // R4
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse); // R2
  AST_RX_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> slot_done); // R7
  AST_REQ_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(fall)); // R8

endmodule

// File: rtl/swire_slave_link.sv
module swire_slave_link #(
  parameter int unsigned RST_CYC      = 4800,
  parameter int unsigned OD_RST_MIN   = 480,
  parameter int unsigned OD_RST_MAX   = 800,
  parameter int unsigned PRES_WAIT    = 300,
  parameter int unsigned PRES_LEN     = 1200,
  parameter int unsigned OD_PRES_WAIT = 30,
  parameter int unsigned OD_PRES_LEN  = 120,
  parameter int unsigned SAMP         = 300,
  parameter int unsigned OD_SAMP      = 35,
  parameter int unsigned HOLD         = 150,
  parameter int unsigned OD_HOLD      = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic bus_pull,
  input  logic od_set,
  output logic od_mode,
  input  logic tx_active,
  input  logic tx_bit,
  output logic tx_req,
  output logic rx_bit,
  output logic rx_valid,
  output logic slot_done,
  output logic rst_pulse
);
  import swl_pkg::*;

  localparam int unsigned TMAX = max2(max2(max2(SAMP, OD_SAMP), max2(HOLD, OD_HOLD)),
                                      max2(max2(PRES_WAIT, PRES_LEN),
                                           max2(OD_PRES_WAIT, OD_PRES_LEN)));
  localparam int unsigned TLIM = TMAX + 1;
  localparam int unsigned TW   = $clog2(TLIM + 1);
  localparam int unsigned CW   = $clog2(RST_CYC + 1);

  logic line, fall, rise, freeze, long_hit, od_hit;

  swl_sync u_sync (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .line(line), .fall(fall), .rise(rise)
  );

  swl_low_timer #(
    .RST_CYC(RST_CYC), .OD_RST_MIN(OD_RST_MIN), .OD_RST_MAX(OD_RST_MAX), .CW(CW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .line(line), .rise(rise), .freeze(freeze),
    .od_mode(od_mode), .long_hit(long_hit), .od_hit(od_hit)
  );

  swl_slot_engine #(
    .PRES_WAIT(PRES_WAIT), .PRES_LEN(PRES_LEN),
    .OD_PRES_WAIT(OD_PRES_WAIT), .OD_PRES_LEN(OD_PRES_LEN),
    .SAMP(SAMP), .OD_SAMP(OD_SAMP), .HOLD(HOLD), .OD_HOLD(OD_HOLD),
    .TLIM(TLIM), .TW(TW)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .line(line), .fall(fall),
    .long_hit(long_hit), .od_hit(od_hit), .od_set(od_set),
    .tx_active(tx_active), .tx_bit(tx_bit),
    .bus_pull(bus_pull), .od_mode(od_mode), .tx_req(tx_req),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .slot_done(slot_done),
    .rst_pulse(rst_pulse), .freeze(freeze)
  );

endmodule

// File: tb/swire_slave_link_bench.sv
module swire_slave_link_bench;
  localparam int RST_CYC = 96, OD_MIN = 12, OD_MAX = 20;
  localparam int PW = 6, PL = 20, OPW = 3, OPL = 8;
  localparam int SMP = 10, OSMP = 6, HLD = 5, OHLD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic od_set = 1'b0, tx_active = 1'b0, tx_bit = 1'b1;
  logic bus_pull, od_mode, tx_req, rx_bit, rx_valid, slot_done, rst_pulse;
  wire  bus_in = ~(m_low | bus_pull);

  int n_chk = 0, n_err = 0;
  int n_req = 0, n_rx = 0, n_done = 0, n_rst = 0, last_rx = -1;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  swire_slave_link #(
    .RST_CYC(RST_CYC), .OD_RST_MIN(OD_MIN), .OD_RST_MAX(OD_MAX),
    .PRES_WAIT(PW), .PRES_LEN(PL), .OD_PRES_WAIT(OPW), .OD_PRES_LEN(OPL),
    .SAMP(SMP), .OD_SAMP(OSMP), .HOLD(HLD), .OD_HOLD(OHLD)
  ) u_swire_slave_link (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_pull(bus_pull),
    .od_set(od_set), .od_mode(od_mode), .tx_active(tx_active), .tx_bit(tx_bit),
    .tx_req(tx_req), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .slot_done(slot_done), .rst_pulse(rst_pulse)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_req)    n_req++;
      if (slot_done) n_done++;
      if (rst_pulse) n_rst++;
      if (rx_valid) begin n_rx++; last_rx = int'(rx_bit); end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check_eq(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic t_reset_state();
    check_eq("R1 bus_pull", int'(bus_pull), 0);
    check_eq("R1 od_mode", int'(od_mode), 0);
    check_eq("R1 strobes", int'(tx_req | rx_valid | slot_done | rst_pulse), 0);
  endtask

  task automatic write_slot(input int len, input int expb, input string tag);
    int r0 = n_rx, d0 = n_done, q0 = n_req, s0 = n_rst;
    m_low = 1'b1;
    repeat (len) tick();
    m_low = 1'b0;
    repeat (40) tick();
    check_eq({tag, " R7 rx count"}, n_rx - r0, 1);
    check_eq({tag, " R7 rx value"}, last_rx, expb);
    check_eq({tag, " R7 done count"}, n_done - d0, 1);
    check_eq({tag, " R6 no reset"}, n_rst - s0, 0);
    check_eq({tag, " R8 req count"}, n_req - q0, 1);
  endtask

  task automatic read_slot(input logic b, input int exp_pull, input string tag);
    int r0 = n_rx, d0 = n_done, q0 = n_req, pulls = 0;
    tx_active = 1'b1;
    tx_bit    = b;
    m_low     = 1'b1;
    for (int i = 0; i < 4; i++) begin tick(); if (bus_pull) pulls++; end
    m_low = 1'b0;
    for (int i = 0; i < 40; i++) begin tick(); if (bus_pull) pulls++; end
    tx_active = 1'b0;
    tx_bit    = 1'b1;
    check_eq({tag, " R9 pull clocks"}, pulls, exp_pull);
    check_eq({tag, " R9 done count"}, n_done - d0, 1);
    check_eq({tag, " R9 no rx"}, n_rx - r0, 0);
    check_eq({tag, " R8 req count"}, n_req - q0, 1);
  endtask

  task automatic bus_reset(input int len, input int exp_gap, input int exp_len,
                           input string tag);
    int s0 = n_rst, d0 = n_done, r0 = n_rx, gap = 0, plen = 0;
    m_low = 1'b1;
    repeat (len) tick();
    m_low = 1'b0;
    do begin tick(); gap++; end while (!bus_pull && gap < 1000);
    while (bus_pull && plen < 5000) begin plen++; tick(); end
    repeat (6) tick();
    check_eq({tag, " R2 reset strobes"}, n_rst - s0, 1);
    check_eq({tag, " R2 no done"}, n_done - d0, 0);
    check_eq({tag, " R2 no rx"}, n_rx - r0, 0);
    check_eq({tag, " R3 presence gap"}, gap, exp_gap);
    check_eq({tag, " R3 presence width"}, plen, exp_len);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset_state();

    write_slot(2, 1, "reg w1");
    write_slot(16, 0, "reg w0 R6 fast-length low");
    read_slot(1'b0, HLD, "reg r0");
    read_slot(1'b1, 0, "reg r1");
    bus_reset(120, PW + 3, PL, "reg reset");
    check_eq("R5 od after reg reset", int'(od_mode), 0);

    od_set = 1'b1; tick(); od_set = 1'b0; tick();
    check_eq("R10 od set", int'(od_mode), 1);

    write_slot(2, 1, "od w1");
    write_slot(10, 0, "od w0 R6 short");
    read_slot(1'b0, OHLD, "od r0");
    bus_reset(16, OPW + 3, OPL, "od R4 fast reset");
    check_eq("R4 od kept", int'(od_mode), 1);
    write_slot(30, 0, "od R6 long non-reset");

    tx_active = 1'b1; tx_bit = 1'b0;
    bus_reset(120, PW + 3, PL, "od R5 long reset mid-tx");
    tx_active = 1'b0; tx_bit = 1'b1;
    check_eq("R5 od cleared", int'(od_mode), 0);
    write_slot(16, 0, "reg after clear");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule